// File: doc/BRIEF.md
# AUX Request Framer and Reply Checker

This block turns one DisplayPort AUX or I2C-over-AUX request into the byte stream that goes on the channel, then judges the reply that comes back. The caller first loads any write payload into a small buffer. It then pulses `start` together with a 4-bit command, a 20-bit address and a length from 0 to `MAX_LEN`. The block offers the header bytes, and for write commands the payload bytes, one at a time on a valid/ready stream.

After the last request byte is taken, the block collects reply bytes from the receiver. A closing pulse carries the receiver's error flags. From these the block decides a result class, captures the reply code and works out how many data bytes were returned. On an acknowledged reply the data bytes can be read back by index. The result is held, with `done` high, until the caller acknowledges it. Only then is a new request accepted.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset `done` and `txValid` are low, and `result` and `dataCount` are 0.
- R2: The first request byte is `{cmd, addr[19:16]}`, the second is `addr[15:8]` and the third is `addr[7:0]`.
- R3: When the length is nonzero, a fourth header byte equal to length−1 follows the address. When the length is zero the header is three bytes long.
- R4: Commands 4'h8, 4'h0 and 4'h4 are writes. For a write, the payload bytes follow the header in buffer order, so the total is header plus length. Every other command sends the header only.
- R5: `txByte` holds its value while `txValid` is high and `txReady` is low. The stream moves on by exactly one byte per accepted transfer. `txValid` falls after the last byte is accepted.
- R6: `replyCode` is the upper nibble of the first reply byte. Data bytes are returned on `rdByte` only when that code is 0 (ACK) and the result is OK. Otherwise `rdByte` reads 0.
- R7: A reply with zero bytes and no error flag gives result INVALID (2). Otherwise the reported `dataCount` is the reply byte count minus one.
- R8: Error flags are checked in a fixed order. Disconnect (`rxFlags[5]`) gives DISCON (3) ahead of everything else. Timeout (`rxFlags[4]`) gives TIMEOUT (1) ahead of the four invalid flags (`rxFlags[3:0]`), and any of those gives INVALID (2).
- R9: If an ACK reply carries more data bytes than the requested length, the result is OVERFLOW (4).
- R10: `done` rises on the edge after the `rxDone` pulse. It stays high, with `result` stable, until `doneAck`. A `start` arriving while the block is busy or done has no effect.
- R11: On any result other than OK (0), `dataCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (taken only when idle) |
| cmd | input | 4 | Request command |
| addr | input | 20 | Request address |
| reqLen | input | LEN_W | Payload/request length, 0..MAX_LEN |
| wrLoadEn | input | 1 | Write strobe for the payload buffer |
| wrLoadIdx | input | IDX_W | Payload buffer slot |
| wrLoadByte | input | 8 | Payload byte |
| txValid | output | 1 | Request byte offered |
| txReady | input | 1 | Request byte accepted |
| txByte | output | 8 | Request byte |
| rxValid | input | 1 | Reply byte present |
| rxByte | input | 8 | Reply byte |
| rxDone | input | 1 | Reply finished; flags valid |
| rxFlags | input | 6 | {disconnect, timeout, invalid-stop, no-detect, invalid-high, invalid-low} |
| done | output | 1 | Result final |
| doneAck | input | 1 | Caller releases the result |
| result | output | 3 | 0 OK, 1 TIMEOUT, 2 INVALID, 3 DISCON, 4 OVERFLOW |
| replyCode | output | 4 | Upper nibble of first reply byte |
| dataCount | output | CNT_W | Reply data byte count |
| rdIdx | input | IDX_W | Reply data read index |
| rdByte | output | 8 | Reply data byte at `rdIdx` |

## Verification
Request bytes are combinational from registered state. The bench therefore samples each one on the falling edge of the cycle in which it sets `txReady`, and the next byte becomes due one edge after each accepted transfer. The result, reply code and data count are all registered on the edge that sees `rxDone`. The bench confirms `done` is still low just before that edge and reads the result on the falling edge that follows. Read-back data is combinational from `rdIdx`, so the bench checks it shortly after changing the index, with no edge in between.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_TIMEOUT  = 3'd1,
    RES_INVALID  = 3'd2,
    RES_DISCON   = 3'd3,
    RES_OVERFLOW = 3'd4
  } resClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic txAdvance;
    logic rxCapture;
    logic classify;
  } ctrlStrobe_t;

  localparam int FLAG_DISC  = 5;
  localparam int FLAG_TMO   = 4;
  localparam int FLAG_W     = 6;

  function automatic logic isWriteCmd(input logic [3:0] c);
    return (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
  endfunction

endpackage

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
  import aux_xact_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        doneAck,
  input  logic        txReady,
  input  logic        rxValid,
  input  logic        rxDone,
  input  logic        txLast,
  output ctrlStrobe_t strobe,
  output logic        txValid,
  output logic        done
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_DONE} state_e;
  state_e st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext  = st;
    strobe  = '0;
    txValid = 1'b0;
    done    = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        strobe.latchReq = 1'b1;
        stNext = ST_SEND;
      end
      ST_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          strobe.txAdvance = 1'b1;
          if (txLast) stNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rxDone) begin
          strobe.classify = 1'b1;
          stNext = ST_DONE;
        end else if (rxValid) begin
          strobe.rxCapture = 1'b1;
        end
      end
      ST_DONE: begin
        done = 1'b1;
        if (doneAck) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/aux_xact_dpath.sv
module aux_xact_dpath
  import aux_xact_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int IDX_W = $clog2(MAX_LEN),
  localparam int CNT_W = LEN_W + 1,
  localparam int TX_W  = $clog2(MAX_LEN + 5)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [3:0]         cmdIn,
  input  logic [19:0]        addrIn,
  input  logic [LEN_W-1:0]   lenIn,
  input  logic               wrLoadEn,
  input  logic [IDX_W-1:0]   wrLoadIdx,
  input  logic [7:0]         wrLoadByte,
  input  logic [7:0]         rxByte,
  input  logic [FLAG_W-1:0]  rxFlags,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [7:0]         txByte,
  output logic               txLast,
  output logic [3:0]         replyCode,
  output logic [CNT_W-1:0]   dataCount,
  output logic [2:0]         result,
  output logic [7:0]         rdByte
);

  logic [3:0]       cmdQ;
  logic [19:0]      addrQ;
  logic [LEN_W-1:0] lenQ;
  logic [TX_W-1:0]  txIdx;
  logic [CNT_W-1:0] rxCnt;
  logic [3:0]       codeQ;
  resClass_e        resQ, resNext;
  logic [CNT_W-1:0] dataCntQ, cntNext;
  logic [7:0]       wrBuf [MAX_LEN];
  logic [7:0]       rxBuf [MAX_LEN];

  // request framing
  logic             hasLen;
  logic [TX_W-1:0]  hdrLen, txTotal, payOff;
  logic [IDX_W-1:0] paySlot;

  assign hasLen  = (lenQ != '0);
  assign hdrLen  = hasLen ? TX_W'(4) : TX_W'(3);
  assign txTotal = hdrLen + (isWriteCmd(cmdQ) ? TX_W'(lenQ) : TX_W'(0));
  assign txLast  = (txIdx == txTotal - TX_W'(1));
  assign payOff  = txIdx - hdrLen;
  assign paySlot = payOff[IDX_W-1:0];

  always_comb begin
    if (txIdx == TX_W'(0))                 txByte = {cmdQ, addrQ[19:16]};
    else if (txIdx == TX_W'(1))            txByte = addrQ[15:8];
    else if (txIdx == TX_W'(2))            txByte = addrQ[7:0];
    else if (txIdx == TX_W'(3) && hasLen)  txByte = 8'(lenQ - LEN_W'(1));
    else                                   txByte = wrBuf[paySlot];
  end

  always_ff @(posedge clk) begin
    if (wrLoadEn && int'(wrLoadIdx) < MAX_LEN) wrBuf[wrLoadIdx] <= wrLoadByte;
  end

  // reply capture
  logic [CNT_W-1:0] rxSlotFull;
  logic [IDX_W-1:0] rxSlot;
  assign rxSlotFull = rxCnt - CNT_W'(1);
  assign rxSlot     = rxSlotFull[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (strobe.rxCapture && rxCnt != '0 && int'(rxCnt) <= MAX_LEN)
      rxBuf[rxSlot] <= rxByte;
  end

  // classification in fixed priority order
  always_comb begin
    resNext = RES_OK;
    cntNext = '0;
    if (rxFlags[FLAG_DISC])          resNext = RES_DISCON;
    else if (rxFlags[FLAG_TMO])      resNext = RES_TIMEOUT;
    else if (|rxFlags[3:0])          resNext = RES_INVALID;
    else if (rxCnt == '0)            resNext = RES_INVALID;
    else if (codeQ == 4'h0 && rxSlotFull > CNT_W'(lenQ))
                                     resNext = RES_OVERFLOW;
    else                             cntNext = rxSlotFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= '0;
      addrQ    <= '0;
      lenQ     <= '0;
      txIdx    <= '0;
      rxCnt    <= '0;
      codeQ    <= '0;
      resQ     <= RES_OK;
      dataCntQ <= '0;
    end else begin
      if (strobe.latchReq) begin
        cmdQ  <= cmdIn;
        addrQ <= addrIn;
        lenQ  <= lenIn;
        txIdx <= '0;
        rxCnt <= '0;
        codeQ <= '0;
      end
      if (strobe.txAdvance) txIdx <= txIdx + TX_W'(1);
      if (strobe.rxCapture) begin
        if (rxCnt == '0) codeQ <= rxByte[7:4];
        if (rxCnt != '1) rxCnt <= rxCnt + CNT_W'(1);
      end
      if (strobe.classify) begin
        resQ     <= resNext;
        dataCntQ <= cntNext;
      end
    end
  end

  assign replyCode = codeQ;
  assign dataCount = dataCntQ;
  assign result    = resQ;
  assign rdByte    = (resQ == RES_OK && codeQ == 4'h0 && CNT_W'(rdIdx) < dataCntQ)
                     ? rxBuf[rdIdx] : 8'h00;

endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_xact_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int IDX_W = $clog2(MAX_LEN),
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        cmd,
  input  logic [19:0]       addr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              wrLoadEn,
  input  logic [IDX_W-1:0]  wrLoadIdx,
  input  logic [7:0]        wrLoadByte,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txByte,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxDone,
  input  logic [5:0]        rxFlags,
  output logic              done,
  input  logic              doneAck,
  output logic [2:0]        result,
  output logic [3:0]        replyCode,
  output logic [CNT_W-1:0]  dataCount,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [7:0]        rdByte
);

  ctrlStrobe_t strobe;
  logic        txLast;

  aux_xact_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .doneAck(doneAck),
    .txReady(txReady), .rxValid(rxValid), .rxDone(rxDone), .txLast(txLast),
    .strobe(strobe), .txValid(txValid), .done(done)
  );

  aux_xact_dpath #(.MAX_LEN(MAX_LEN)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdIn(cmd), .addrIn(addr), .lenIn(reqLen),
    .wrLoadEn(wrLoadEn), .wrLoadIdx(wrLoadIdx), .wrLoadByte(wrLoadByte),
    .rxByte(rxByte), .rxFlags(rxFlags), .rdIdx(rdIdx),
    .txByte(txByte), .txLast(txLast), .replyCode(replyCode),
    .dataCount(dataCount), .result(result), .rdByte(rdByte)
  );

endmodule

// File: rtl/aux_xact_checker.sv
module aux_xact_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             done,
  input logic             doneAck,
  input logic             txValid,
  input logic             txReady,
  input logic [7:0]       txByte,
  input logic [2:0]       result,
  input logic [CNT_W-1:0] dataCount
);

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !doneAck |=> done && $stable(result));

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && doneAck |=> !done);

  // R11
  fail_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && result != 3'd0 |-> dataCount == '0);

endmodule

bind aux_xact_engine aux_xact_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .doneAck(doneAck),
  .txValid(txValid), .txReady(txReady), .txByte(txByte),
  .result(result), .dataCount(dataCount)
);

// File: tb/aux_xact_engine_test.sv
module aux_xact_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 16;
  localparam int LEN_W = 5;
  localparam int IDX_W = 4;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] cmd = '0;
  logic [19:0] addr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic wrLoadEn = 1'b0;
  logic [IDX_W-1:0] wrLoadIdx = '0;
  logic [7:0] wrLoadByte = '0;
  logic txValid, done;
  logic txReady = 1'b0;
  logic [7:0] txByte, rdByte;
  logic rxValid = 1'b0, rxDone = 1'b0, doneAck = 1'b0;
  logic [7:0] rxByte = '0;
  logic [5:0] rxFlags = '0;
  logic [2:0] result;
  logic [3:0] replyCode;
  logic [CNT_W-1:0] dataCount;
  logic [IDX_W-1:0] rdIdx = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_xact_engine #(.MAX_LEN(MAX_LEN)) uut (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .addr(addr),
    .reqLen(reqLen), .wrLoadEn(wrLoadEn), .wrLoadIdx(wrLoadIdx),
    .wrLoadByte(wrLoadByte), .txValid(txValid), .txReady(txReady),
    .txByte(txByte), .rxValid(rxValid), .rxByte(rxByte), .rxDone(rxDone),
    .rxFlags(rxFlags), .done(done), .doneAck(doneAck), .result(result),
    .replyCode(replyCode), .dataCount(dataCount), .rdIdx(rdIdx), .rdByte(rdByte)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] wrPat(input int c, input int i, input int len);
    return 8'(c * 16 + i * 3 + len + 5);
  endfunction

  function automatic logic [7:0] rxPat(input logic [19:0] a, input int i);
    return 8'(int'(a[7:0]) + i * 7 + 1);
  endfunction

  task automatic runTxn(input logic [3:0] c, input logic [19:0] a, input int len, input int kind);
    bit isWr = (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
    int hdr = (len != 0) ? 4 : 3;
    int n = hdr + (isWr ? len : 0);
    int got = 0;
    int guard = 0;
    int nb, code, expRes, expCnt, bad;
    logic [5:0] fl;
    logic [7:0] expB;
    string tag;
    // load payload
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wrLoadEn = 1'b1; wrLoadIdx = IDX_W'(i); wrLoadByte = wrPat(c, i, len);
    end
    @(negedge clk);
    wrLoadEn = 1'b0;
    cmd = c; addr = a; reqLen = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (got < n && guard < 200) begin
      // a start while sending must be ignored (R10)
      if (guard == 0 && kind[0]) begin start = 1'b1; cmd = ~c; addr = ~a; reqLen = '0; end
      else start = 1'b0;
      txReady = ((guard % 3) != 1);
      if (txValid && txReady) begin
        if (got == 0)      begin expB = {c, a[19:16]}; tag = "R2"; end
        else if (got == 1) begin expB = a[15:8]; tag = "R2"; end
        else if (got == 2) begin expB = a[7:0]; tag = "R2"; end
        else if (got == 3 && len != 0) begin expB = 8'(len - 1); tag = "R3"; end
        else begin expB = wrPat(c, got - hdr, len); tag = "R4"; end
        check(tag, $sformatf("tx byte %0d cmd=%h len=%0d", got, c, len), int'(txByte), int'(expB));
        got++;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0; txReady = 1'b0;
    check("R4", "request byte total", got, n);
    check("R5", "txValid low after last byte", int'(txValid), 0);

    // build reply
    fl = '0; code = 0; nb = len + 1; expRes = 0; expCnt = len;
    case (kind)
      0: ;
      1: begin nb = len + 2; expRes = 4; expCnt = 0; end
      2: begin nb = 1; code = 1; expCnt = 0; end
      3: begin nb = 0; expRes = 2; expCnt = 0; end
      4: begin fl = 6'b011000; expRes = 1; expCnt = 0; end
      5: begin fl = 6'b110000; expRes = 3; expCnt = 0; end
      6: begin fl = (len == 0) ? 6'b000110 : 6'b000001; expRes = 2; expCnt = 0; end
      default: begin nb = 3; code = 2; expCnt = 2; end
    endcase
    for (int b = 0; b < nb; b++) begin
      rxValid = 1'b1;
      rxByte = (b == 0) ? 8'(code << 4) : rxPat(a, b - 1);
      @(negedge clk);
    end
    rxValid = 1'b0; rxDone = 1'b1; rxFlags = fl;
    check("R10", "done still low before close edge", int'(done), 0);
    @(negedge clk);
    rxDone = 1'b0; rxFlags = '0;
    check("R10", "done one edge after rxDone", int'(done), 1);
    tag = (kind == 1) ? "R9" : (kind == 3) ? "R7" : (kind >= 4 && kind <= 6) ? "R8" : "R7";
    check(tag, $sformatf("result kind=%0d len=%0d", kind, len), int'(result), expRes);
    check("R6", $sformatf("reply code kind=%0d", kind), int'(replyCode), code);
    check(expRes != 0 ? "R11" : "R7", $sformatf("dataCount kind=%0d len=%0d", kind, len),
          int'(dataCount), expCnt);
    bad = 0;
    for (int i = 0; i < MAX_LEN; i++) begin
      rdIdx = IDX_W'(i);
      #1;
      expB = (kind == 0 && i < len) ? rxPat(a, i) : 8'h00;
      if (rdByte !== expB) bad++;
    end
    check("R6", $sformatf("read-back mismatches kind=%0d len=%0d", kind, len), bad, 0);

    // start while done is ignored
    @(negedge clk);
    start = 1'b1; cmd = 4'h9; reqLen = '0;
    @(negedge clk);
    start = 1'b0;
    check("R10", "done held across ignored start", int'(done), 1);
    check("R10", "no request from ignored start", int'(txValid), 0);
    doneAck = 1'b1;
    @(negedge clk);
    doneAck = 1'b0;
    check("R10", "done cleared by ack", int'(done), 0);
    check("R10", "idle after ack", int'(txValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] cmds [8];
    int lens [4];
    cmds[0] = 4'h8; cmds[1] = 4'h9; cmds[2] = 4'h0; cmds[3] = 4'h1;
    cmds[4] = 4'h4; cmds[5] = 4'h5; cmds[6] = 4'h2; cmds[7] = 4'hA;
    lens[0] = 0; lens[1] = 1; lens[2] = 3; lens[3] = MAX_LEN;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "txValid after reset", int'(txValid), 0);
    check("R1", "result after reset", int'(result), 0);
    check("R1", "dataCount after reset", int'(dataCount), 0);
    for (int ci = 0; ci < 8; ci++)
      for (int li = 0; li < 4; li++)
        for (int k = 0; k < 8; k++)
          runTxn(cmds[ci], 20'(ci * 65536 + li * 4660 + k * 91 + 60), lens[li], k);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule